// File: doc/BRIEF.md
# Nonvolatile Save and Restore Controller

This block sequences the bulk transfers between a volatile working array and the nonvolatile shadow copy behind it. A save erases the shadow copy and then programs every shadow cell in parallel from the working array. A restore clears the working array and then copies the shadow contents into it; it never changes the shadow copy. Each phase drives one control output for a fixed number of clock cycles, and each phase length is a parameter. The array storage, the analog supply sensing and the address-sequence detector are outside the block.

Requests come from three places. The sequence detector issues single-cycle software save and restore pulses. A supply-good input reports whether the supply is above the switching threshold. Supply loss triggers an automatic save, but only when the working array has been written since the last completed transfer. Any period of low supply latches a pending restore, which runs once the supply is good again. That pending restore is also how the power-up restore happens, since the block leaves reset in its low-supply state. While a transfer runs, or while the supply is low, the block holds `busy` high. It also blocks the external read and write strobes from reaching the array and ignores new software requests.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: After reset the block waits in its low-supply state: `busy` is 1, `nv_erase`, `nv_prog`, `vol_clear` and `vol_copy` are all 0, and a restore is pending.
- R2: When `pwr_ok` is 1 with a restore pending, `vol_clear` is high for CLEAR_CYC cycles. Then `vol_copy` is high for COPY_PU_CYC cycles. Then `busy` returns to 0.
- R3: A `sw_save_req` pulse while idle with `pwr_ok` at 1 gives `nv_erase` for ERASE_CYC cycles and then `nv_prog` for PROG_CYC cycles. This happens whether or not the array was written.
- R4: A `sw_restore_req` pulse while idle with `pwr_ok` at 1 gives `vol_clear` for CLEAR_CYC cycles and then `vol_copy` for COPY_SW_CYC cycles.
- R5: If `pwr_ok` falls while idle and the array is dirty, a full save (erase, then program) runs. If the array is clean, no erase or program occurs. Either way `busy` stays 1 until the supply is good again.
- R6: An accepted write (`wr_stb` while `busy` is 0) marks the array dirty. A completed save or restore marks it clean. A write strobe while `busy` is 1 does not mark it dirty.
- R7: `ext_rd_en` and `ext_wr_en` follow `rd_stb` and `wr_stb` only while `busy` is 0. Software requests that arrive while `busy` is 1 are ignored.
- R8: A software save request while `pwr_ok` is 0 starts no erase or program.
- R9: If `pwr_ok` drops during a software save, `nv_erase`/`nv_prog` drop on the next cycle. The save is not finished. A restore follows once `pwr_ok` returns.
- R10: A restore is never cut short by `pwr_ok` falling. The low-supply period latches a further restore, and that restore runs with the power-up copy length after the supply returns.
- R11: At most one of the four transfer controls is high in any cycle. `nv_prog` only begins right after an `nv_erase` cycle, and `vol_copy` only begins right after a `vol_clear` cycle.
- R12: When both software requests arrive in the same cycle, the save is performed and the restore is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| pwr_ok | input | 1 | Supply above switching threshold |
| sw_save_req | input | 1 | Software save pulse from the sequence detector |
| sw_restore_req | input | 1 | Software restore pulse from the sequence detector |
| rd_stb | input | 1 | External read strobe |
| wr_stb | input | 1 | External write strobe |
| ext_rd_en | output | 1 | Read strobe passed to the array |
| ext_wr_en | output | 1 | Write strobe passed to the array |
| nv_erase | output | 1 | Erase shadow copy |
| nv_prog | output | 1 | Program shadow copy from working array |
| vol_clear | output | 1 | Clear working array |
| vol_copy | output | 1 | Copy shadow copy into working array |
| busy | output | 1 | Transfer running or supply low; feeds the sequence detector |

## Verification
Several corner cases each expose a specific fault:
- Supply loss with a clean array must not save. A design that ignores the dirty flag would show an erase and program there.
- Writes attempted during a restore must not mark the array dirty. A design that counts them would run an auto save at the next supply loss.
- A supply drop partway through a software save must cut the erase short. A design that instead lets the save run on would show the full erase and a program phase.
- A supply drop during a software restore must not cut it short. It must instead queue a second restore with the power-up copy length, so a design that aborts it, or forgets the latch, reports the wrong clear and copy totals.
- The power-up copy length and the software copy length must be kept apart. A design that mixes them up reports the wrong copy totals.

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl #(
  parameter int ERASE_CYC   = 1_000_000,
  parameter int PROG_CYC    = 1_000_000,
  parameter int CLEAR_CYC   = 400,
  parameter int COPY_SW_CYC = 3_600,
  parameter int COPY_PU_CYC = 129_600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic sw_save_req,
  input  logic sw_restore_req,
  input  logic rd_stb,
  input  logic wr_stb,
  output logic ext_rd_en,
  output logic ext_wr_en,
  output logic nv_erase,
  output logic nv_prog,
  output logic vol_clear,
  output logic vol_copy,
  output logic busy
);

  localparam int M1   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int M2   = (CLEAR_CYC > COPY_SW_CYC) ? CLEAR_CYC : COPY_SW_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > COPY_PU_CYC) ? M3 : COPY_PU_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] CLEAR_LD = CW'(CLEAR_CYC - 1);
  localparam logic [CW-1:0] CPSW_LD  = CW'(COPY_SW_CYC - 1);
  localparam logic [CW-1:0] CPPU_LD  = CW'(COPY_PU_CYC - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE, ST_PROGRAM, ST_CLEAR, ST_COPY, ST_POWERDOWN
  } st_t;

  st_t           state, nxt;
  logic [CW-1:0] cnt;
  logic          dirty, pend, sw_kind, pu_kind;
  logic          nxt_sw, nxt_pu;
  logic          last, abort, done;

  assign last  = (cnt == '0);
  assign abort = sw_kind && !pwr_ok && (state == ST_ERASE || state == ST_PROGRAM);
  assign done  = last && ((state == ST_PROGRAM && !abort) || state == ST_COPY);

  assign busy      = (state != ST_IDLE);
  assign ext_rd_en = rd_stb && !busy;
  assign ext_wr_en = wr_stb && !busy;
  assign nv_erase  = (state == ST_ERASE);
  assign nv_prog   = (state == ST_PROGRAM);
  assign vol_clear = (state == ST_CLEAR);
  assign vol_copy  = (state == ST_COPY);

  always_comb begin
    nxt    = state;
    nxt_sw = sw_kind;
    nxt_pu = pu_kind;
    unique case (state)
      ST_IDLE: begin
        if (!pwr_ok) begin
          if (dirty) begin
            nxt    = ST_ERASE;
            nxt_sw = 1'b0;
          end else begin
            nxt = ST_POWERDOWN;
          end
        end else if (sw_save_req) begin
          nxt    = ST_ERASE;
          nxt_sw = 1'b1;
        end else if (sw_restore_req) begin
          nxt    = ST_CLEAR;
          nxt_pu = 1'b0;
        end
      end
      ST_ERASE: begin
        if (abort)     nxt = ST_POWERDOWN;
        else if (last) nxt = ST_PROGRAM;
      end
      ST_PROGRAM: begin
        if (abort) nxt = ST_POWERDOWN;
      end
      ST_CLEAR: begin
        if (last) nxt = ST_COPY;
      end
      ST_COPY: ;
      ST_POWERDOWN: begin
        if (pwr_ok) begin
          if (pend) begin
            nxt    = ST_CLEAR;
            nxt_pu = 1'b1;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      default: nxt = ST_POWERDOWN;
    endcase
    if (done) begin
      if (!pwr_ok) begin
        nxt = ST_POWERDOWN;
      end else if (pend) begin
        nxt    = ST_CLEAR;
        nxt_pu = 1'b1;
      end else begin
        nxt = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_POWERDOWN;
      cnt     <= '0;
      dirty   <= 1'b0;
      pend    <= 1'b1;
      sw_kind <= 1'b0;
      pu_kind <= 1'b1;
    end else begin
      state   <= nxt;
      sw_kind <= nxt_sw;
      pu_kind <= nxt_pu;
      if (nxt != state) begin
        unique case (nxt)
          ST_ERASE:   cnt <= ERASE_LD;
          ST_PROGRAM: cnt <= PROG_LD;
          ST_CLEAR:   cnt <= CLEAR_LD;
          ST_COPY:    cnt <= pu_kind ? CPPU_LD : CPSW_LD;
          default:    cnt <= '0;
        endcase
      end else if (!last) begin
        cnt <= cnt - 1'b1;
      end
      if (done)           dirty <= 1'b0;
      else if (ext_wr_en) dirty <= 1'b1;
      if (!pwr_ok)                                  pend <= 1'b1;
      else if (nxt == ST_CLEAR && state != ST_CLEAR) pend <= 1'b0;
    end
  end

  // R11
  onehot_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nv_erase, nv_prog, vol_clear, vol_copy}));

  // R11
  prog_after_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_prog) |-> $past(nv_erase));

  // R11
  copy_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vol_copy) |-> $past(vol_clear));

  // R5
  clean_no_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pwr_ok && !dirty) |=> !nv_erase);

  // R10
  restore_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_clear && !pwr_ok) |=> (vol_clear || vol_copy));

  // R6
  clean_after_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vol_copy) |-> !dirty);

  // R9
  sw_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((nv_erase || nv_prog) && sw_kind && !pwr_ok) |=> !(nv_erase || nv_prog));

endmodule

// File: tb/nv_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module nv_xfer_ctrl_tb_top;
  localparam int E  = 8;
  localparam int P  = 12;
  localparam int C  = 4;
  localparam int SW = 6;
  localparam int PU = 20;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, sw_save_req, sw_restore_req, rd_stb, wr_stb;
  logic ext_rd_en, ext_wr_en, nv_erase, nv_prog, vol_clear, vol_copy, busy;

  int checks = 0;
  int fails = 0;
  int ce, cp, cc, cy, order_err;
  logic pe, pc;
  bit dirty_m;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nv_xfer_ctrl #(.ERASE_CYC(E), .PROG_CYC(P), .CLEAR_CYC(C),
                 .COPY_SW_CYC(SW), .COPY_PU_CYC(PU)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .sw_save_req(sw_save_req),
    .sw_restore_req(sw_restore_req), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .ext_rd_en(ext_rd_en), .ext_wr_en(ext_wr_en), .nv_erase(nv_erase),
    .nv_prog(nv_prog), .vol_clear(vol_clear), .vol_copy(vol_copy), .busy(busy));

  always @(negedge clk) begin
    if (!rst_n) begin
      pe <= 1'b0; pc <= 1'b0;
    end else begin
      ce <= ce + int'(nv_erase);
      cp <= cp + int'(nv_prog);
      cc <= cc + int'(vol_clear);
      cy <= cy + int'(vol_copy);
      if ((int'(nv_erase) + int'(nv_prog) + int'(vol_clear) + int'(vol_copy)) > 1) order_err <= order_err + 1;
      if (nv_prog && !pe && !dut_prev_prog) order_err <= order_err + 1;
      if (vol_copy && !pc && !dut_prev_copy) order_err <= order_err + 1;
      pe <= nv_erase; pc <= vol_clear;
      dut_prev_prog <= nv_prog; dut_prev_copy <= vol_copy;
    end
  end
  logic dut_prev_prog = 1'b0, dut_prev_copy = 1'b0;

  function automatic int exp_save_len(bit dirty, bit sw);
    return (dirty || sw) ? E : 0;
  endfunction

  function automatic int exp_copy_len(bit pu);
    return pu ? PU : SW;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_meas();
    ce = 0; cp = 0; cc = 0; cy = 0; order_err = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(string req);
    int lim = 0;
    while (busy && lim < 2000) begin
      @(negedge clk);
      lim++;
    end
    chk({req, " busy clears"}, int'(busy), 0);
  endtask

  task automatic phases(string req, int e, int p, int c, int y);
    chk({req, " erase cycles"}, ce, e);
    chk({req, " program cycles"}, cp, p);
    chk({req, " clear cycles"}, cc, c);
    chk({req, " copy cycles"}, cy, y);
    chk("R11 ordering", order_err, 0);
  endtask

  task automatic pulse_save();
    sw_save_req = 1'b1; step(1); sw_save_req = 1'b0;
  endtask

  task automatic pulse_restore();
    sw_restore_req = 1'b1; step(1); sw_restore_req = 1'b0;
  endtask

  task automatic do_write();
    wr_stb = 1'b1; #1;
    chk("R7 write passes when idle", int'(ext_wr_en), 1);
    step(1); wr_stb = 1'b0;
    dirty_m = 1'b1;
  endtask

  task automatic power_cycle(string req, int hold);
    int es;
    es = exp_save_len(dirty_m, 1'b0);
    clr_meas();
    pwr_ok = 1'b0; step(hold);
    chk({req, " busy while supply low"}, int'(busy), 1);
    pwr_ok = 1'b1;
    step(1);
    wait_idle(req);
    phases(req, es, (es != 0) ? P : 0, C, exp_copy_len(1'b1));
    dirty_m = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; pwr_ok = 1'b0; sw_save_req = 1'b0; sw_restore_req = 1'b0;
    rd_stb = 1'b0; wr_stb = 1'b0; dirty_m = 1'b0;
    void'($urandom(32'h5EED_0C1A));
    clr_meas();
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 busy after reset", int'(busy), 1);
    chk("R1 controls low after reset",
        int'(nv_erase) + int'(nv_prog) + int'(vol_clear) + int'(vol_copy), 0);
    rd_stb = 1'b1; wr_stb = 1'b1; #1;
    chk("R7 read gated while low supply", int'(ext_rd_en), 0);
    chk("R7 write gated while low supply", int'(ext_wr_en), 0);
    step(1); rd_stb = 1'b0; wr_stb = 1'b0;
    // R2 power-up restore
    clr_meas();
    pwr_ok = 1'b1; step(1);
    wait_idle("R2");
    phases("R2 power-up restore", 0, 0, C, PU);

    // R3 software save on clean array
    clr_meas(); pulse_save(); wait_idle("R3");
    phases("R3 clean sw save", E, P, 0, 0);
    // R5 clean supply loss: no save
    power_cycle("R5 clean supply loss", 30);
    // R5 R6 dirty supply loss: auto save
    do_write();
    power_cycle("R5 dirty supply loss", 30);

    // R4 software restore, writes and requests during busy ignored (R6 R7)
    clr_meas(); pulse_restore();
    wr_stb = 1'b1; rd_stb = 1'b1; sw_save_req = 1'b1; #1;
    chk("R7 write gated during restore", int'(ext_wr_en), 0);
    chk("R7 read gated during restore", int'(ext_rd_en), 0);
    step(1); wr_stb = 1'b0; rd_stb = 1'b0; sw_save_req = 1'b0;
    wait_idle("R4");
    phases("R4 sw restore, R7 save request ignored", 0, 0, C, SW);
    power_cycle("R6 busy write left array clean", 5);

    // R12 both requests in one cycle
    clr_meas();
    sw_save_req = 1'b1; sw_restore_req = 1'b1; step(1);
    sw_save_req = 1'b0; sw_restore_req = 1'b0;
    wait_idle("R12");
    phases("R12 save wins", E, P, 0, 0);

    // R8 software save while supply low
    clr_meas(); pwr_ok = 1'b0; step(5);
    pulse_save(); step(5);
    pwr_ok = 1'b1; step(1); wait_idle("R8");
    phases("R8 save blocked on low supply", 0, 0, C, PU);

    // R9 software save aborted by supply drop
    do_write();
    clr_meas();
    sw_save_req = 1'b1; step(1); sw_save_req = 1'b0;
    step(3);
    pwr_ok = 1'b0; step(10);
    pwr_ok = 1'b1; step(1); wait_idle("R9");
    phases("R9 aborted sw save", 4, 0, C, PU);
    dirty_m = 1'b0;

    // R10 restore survives supply drop and queues another
    clr_meas(); pulse_restore(); step(2);
    pwr_ok = 1'b0; step(20);
    pwr_ok = 1'b1; step(1); wait_idle("R10");
    phases("R10 restore not aborted", 0, 0, 2 * C, SW + PU);

    // random mix
    for (int i = 0; i < 150; i++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: do_write();
        1: begin
          clr_meas(); pulse_save(); wait_idle("R3");
          phases("R3 random sw save", exp_save_len(dirty_m, 1'b1), P, 0, 0);
          dirty_m = 1'b0;
        end
        2: begin
          clr_meas(); pulse_restore(); wait_idle("R4");
          phases("R4 random sw restore", 0, 0, C, exp_copy_len(1'b0));
          dirty_m = 1'b0;
        end
        3: power_cycle("R5 random supply loss", 1 + int'($urandom % 40));
        default: begin
          rd_stb = 1'b1; #1;
          chk("R7 read passes when idle", int'(ext_rd_en), 1);
          step(1); rd_stb = 1'b0;
        end
      endcase
      step(int'($urandom % 3));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule